// File: doc/BRIEF.md
# Shadow-RAM Store/Recall Controller

This controller sits in front of a byte-wide static RAM whose every cell has a nonvolatile shadow. It decodes user read and write cycles from active-low chip enable, output enable and write enable. It also decodes a shared active-low busy/request line. It grants or refuses each access to the array. It also decides when the whole array is copied into the shadow (a store) or loaded back from it (a recall). The copy itself is outside the block. The controller represents it as a busy period of fixed length. A start pulse opens the period and a done pulse closes it.

A store has three possible triggers. Another agent can pull the shared line low, a power-fail flag can rise, or software can read six fixed addresses back to back. A dirty flag records whether any write was granted since the last copy. The line and power-fail triggers are dropped when the flag is clear. The software trigger always runs. For line and power-fail stores the controller first opens a grace window. During the window, reads and a write already under way can finish. The controller drives the line low for the whole of every store, grace window included. A separate recall request loads the array back from the shadow unconditionally.

Top module: `shadow_ram_ctrl`

## Requirements
- R1: A read is granted (`mem_rd_en`=1) when `ce_n`=0, `oe_n`=0, `we_n`=1 and `req_line_n`=1. With the line low, or with `oe_n`=1, no read is granted.
- R2: A write is granted (`mem_wr_en`=1) when `ce_n`=0, `we_n`=0 and `req_line_n`=1, whatever the level of `oe_n`. A write takes priority over a read. Every granted write sets the dirty flag.
- R3: Every store drives `line_pull`=1 from the first cycle after its trigger until its done pulse, grace window included. This holds for all three triggers.
- R4: A line-low or `power_fail` trigger while the dirty flag is clear starts nothing. `line_pull` stays 0, no transfer starts and `store_count` does not change.
- R5: Six granted reads, each starting on its own, at step addresses 0 to 5 in that order start a store at once, with no grace window. The first transfer cycle follows the clock edge that ends the sixth read. This store runs even when the dirty flag is clear.
- R6: While a transfer runs, `mem_rd_en` and `mem_wr_en` stay 0 whatever the bus inputs.
- R7: A line-low or `power_fail` store first spends exactly GRACE_CYCLES cycles in a grace window. During the window a read is granted without regard to the line. A write granted in the previous cycle keeps being granted while `ce_n` and `we_n` stay low, and any new write is refused.
- R8: A transfer lasts exactly XFER_CYCLES cycles. `xfer_start` is high in its first cycle and `xfer_done` in its last, each for one cycle only. `xfer_store` is 1 for a store and 0 for a recall.
- R9: A read start at an address other than the expected step, or any granted write, returns the sequence matcher to step 0.
- R10: `recall_req` starts a recall transfer in the next cycle, whether or not the dirty flag is set. The line is not pulled. When triggers coincide, recall wins over a software store, and a software store wins over a line-low or power-fail store.
- R11: The done pulse of a store or recall clears the dirty flag.
- R12: `store_count` rises by one when a store completes. It does not change for recalls or skipped stores, and it stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| req_line_n | input | 1 | Observed level of the shared busy/request line |
| line_pull | output | 1 | 1 = controller drives the shared line low |
| power_fail | input | 1 | Supply-loss indication, requests a conditional store |
| recall_req | input | 1 | Requests a recall from the shadow array |
| mem_rd_en | output | 1 | Read granted to the array this cycle |
| mem_wr_en | output | 1 | Write granted to the array this cycle |
| xfer_start | output | 1 | First cycle of a transfer |
| xfer_store | output | 1 | Direction of the running transfer (1 = store) |
| xfer_done | output | 1 | Last cycle of a transfer |
| store_count | output | CNT_W | Saturating count of completed stores |

## Verification
Several rules are checked on every cycle by the assertions. Access stays closed during a transfer. A clean controller never enters a grace window. A write inside the window must carry over from the cycle before. The dirty flag is clear right after a done pulse, the done pulse lasts one cycle, the counter only moves after a done pulse and holds once saturated, and the matcher returns to step 0 after a write. Other behaviour can only be seen in the bench scenarios. These include the exact length of the grace window and of the transfer, and the six-read order being honoured or broken. They also cover the three store triggers and their line pull, recall direction and its clearing of the dirty flag, and skipped stores leaving the counter unchanged.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_GRACE = 2'd1,
      PH_XFER  = 2'd2
   } phase_e;

endpackage

// File: rtl/seq_matcher.sv
module seq_matcher #(
   parameter int AW    = 15,
   parameter int STEPS = 6,
   parameter logic [STEPS*AW-1:0] SEQ = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          rd_start,
   input  logic          wr_seen,
   input  logic [AW-1:0] addr,
   output logic          fire
);
   localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   initial begin
      if (STEPS < 2) $fatal(1, "seq_matcher: STEPS must be at least 2");
      if (AW < 1)    $fatal(1, "seq_matcher: AW must be at least 1");
   end

   logic [STEPS-1:0] hit;
   logic [SW-1:0]    step;
   logic             cur_hit;

   for (genvar i = 0; i < STEPS; i++) begin : g_cmp
      assign hit[i] = (addr == SEQ[i*AW +: AW]);
   end

   always_comb begin
      cur_hit = 1'b0;
      for (int k = 0; k < STEPS; k++)
         if (step == SW'(k)) cur_hit = hit[k];
   end

   assign fire = enable && rd_start && cur_hit && (step == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step <= '0;
      else if (wr_seen)
         step <= '0;
      else if (enable && rd_start) begin
         if (cur_hit && step != LAST)
            step <= step + 1'b1;
         else
            step <= '0;
      end
   end

   AST_SEQ_WRITE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |=> (step == '0)) else $error("matcher not reset by write"); // R9

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   output logic [CW-1:0] count
);
   initial begin
      if (CW < 1) $fatal(1, "phase_timer: CW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clear)
         count <= '0;
      else if (count != '1)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/shadow_ram_ctrl.sv
module shadow_ram_ctrl
   import shadow_pkg::*;
#(
   parameter int AW           = 15,
   parameter int GRACE_CYCLES = 4,
   parameter int XFER_CYCLES  = 32,
   parameter int CNT_W        = 8,
   parameter int SEQ_STEPS    = 6,
   parameter logic [SEQ_STEPS*AW-1:0] SEQ_ADDRS =
      {15'h43C3, 15'h3C3C, 15'h70F0, 15'h0F0F, 15'h25A5, 15'h1A5A}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic [AW-1:0]    addr,
   input  logic             req_line_n,
   output logic             line_pull,
   input  logic             power_fail,
   input  logic             recall_req,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic             xfer_start,
   output logic             xfer_store,
   output logic             xfer_done,
   output logic [CNT_W-1:0] store_count
);
   localparam int TMAX = (GRACE_CYCLES > XFER_CYCLES) ? GRACE_CYCLES : XFER_CYCLES;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0]    G_LAST = TW'(GRACE_CYCLES - 1);
   localparam logic [TW-1:0]    X_LAST = TW'(XFER_CYCLES - 1);
   localparam logic [CNT_W-1:0] CMAX   = '1;

   initial begin
      if (GRACE_CYCLES < 1) $fatal(1, "shadow_ram_ctrl: GRACE_CYCLES must be >= 1");
      if (XFER_CYCLES < 1)  $fatal(1, "shadow_ram_ctrl: XFER_CYCLES must be >= 1");
      if (CNT_W < 1)        $fatal(1, "shadow_ram_ctrl: CNT_W must be >= 1");
      if (AW < 1)           $fatal(1, "shadow_ram_ctrl: AW must be >= 1");
   end

   phase_e        phase, phase_nx;
   logic          dirty, wr_prev, rd_prev, store_dir;
   logic [TW-1:0] tcnt;
   logic          rd_req, wr_req, rd_cycle, wr_cycle, wr_cont;
   logic          rd_start, sw_fire, hw_go;

   // bus decode
   assign rd_req   = !ce_n && !oe_n && we_n;
   assign wr_req   = !ce_n && !we_n;
   assign rd_cycle = rd_req && req_line_n;
   assign wr_cycle = wr_req && req_line_n;
   assign wr_cont  = wr_prev && wr_req;
   assign rd_start = rd_cycle && !rd_prev;

   always_comb begin
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            mem_wr_en = wr_cycle || wr_cont;
            mem_rd_en = rd_cycle && !mem_wr_en;
         end
         PH_GRACE: begin
            mem_wr_en = wr_cont;
            mem_rd_en = rd_req;
         end
         default: ;
      endcase
   end

   seq_matcher #(
      .AW(AW), .STEPS(SEQ_STEPS), .SEQ(SEQ_ADDRS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .enable(phase == PH_IDLE),
      .rd_start(rd_start),
      .wr_seen(mem_wr_en),
      .addr(addr),
      .fire(sw_fire)
   );

   // conditional triggers: line pulled by another agent, or supply loss
   assign hw_go = dirty && (!req_line_n || power_fail);

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: begin
            if (recall_req || sw_fire) phase_nx = PH_XFER;
            else if (hw_go)            phase_nx = PH_GRACE;
         end
         PH_GRACE: if (tcnt == G_LAST) phase_nx = PH_XFER;
         PH_XFER:  if (tcnt == X_LAST) phase_nx = PH_IDLE;
         default:  phase_nx = PH_IDLE;
      endcase
   end

   phase_timer #(.CW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clear(phase_nx != phase),
      .count(tcnt)
   );

   assign xfer_start = (phase == PH_XFER) && (tcnt == '0);
   assign xfer_done  = (phase == PH_XFER) && (tcnt == X_LAST);
   assign xfer_store = store_dir;
   assign line_pull  = store_dir && (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         store_dir <= 1'b0;
         dirty     <= 1'b0;
         wr_prev   <= 1'b0;
         rd_prev   <= 1'b0;
      end else begin
         phase   <= phase_nx;
         wr_prev <= mem_wr_en;
         rd_prev <= rd_cycle;
         if (phase == PH_IDLE && phase_nx != PH_IDLE)
            store_dir <= !recall_req;
         else if (phase_nx == PH_IDLE)
            store_dir <= 1'b0;
         if (xfer_done)      dirty <= 1'b0;
         else if (mem_wr_en) dirty <= 1'b1;
      end
   end

   // completed-store counter, narrow variant avoids the adder
   if (CNT_W == 1) begin : g_cnt1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) store_count <= '0;
         else if (xfer_done && store_dir) store_count <= 1'b1;
      end
   end else begin : g_cntn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) store_count <= '0;
         else if (xfer_done && store_dir && store_count != CMAX)
            store_count <= store_count + 1'b1;
      end
   end

   AST_XFER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_XFER) |-> (!mem_rd_en && !mem_wr_en)) else $error("access during transfer"); // R6
   AST_CLEAN_NO_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !dirty) |=> (phase != PH_GRACE)) else $error("grace while clean"); // R4
   AST_GRACE_NO_NEW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_GRACE && mem_wr_en) |-> $past(mem_wr_en)) else $error("new write in grace"); // R7
   AST_DONE_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !dirty) else $error("dirty survives done"); // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done) else $error("done longer than one cycle"); // R8
   AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (store_count == CMAX) |=> (store_count == CMAX)) else $error("counter wrapped"); // R12
   AST_COUNT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(store_count) |-> $past(xfer_done && xfer_store)) else $error("count moved without store"); // R12

endmodule

// File: tb/shadow_ram_ctrl_test.sv
module shadow_ram_ctrl_test;
   localparam int AW = 15;
   localparam int GR = 3;
   localparam int XF = 6;
   localparam logic [AW-1:0] S0 = 15'h1A5A, S1 = 15'h25A5, S2 = 15'h0F0F,
                             S3 = 15'h70F0, S4 = 15'h3C3C, S5 = 15'h43C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic ext_req_n = 1'b1, power_fail = 1'b0, recall_req = 1'b0;
   logic line_pull, mem_rd_en, mem_wr_en, xfer_start, xfer_store, xfer_done;
   logic [1:0] store_count;
   logic req_line_n;
   int total = 0, bad = 0, starts = 0;

   assign req_line_n = ext_req_n && !line_pull;

   always #4 clk = ~clk;

   shadow_ram_ctrl #(
      .AW(AW), .GRACE_CYCLES(GR), .XFER_CYCLES(XF), .CNT_W(2), .SEQ_STEPS(6),
      .SEQ_ADDRS({S5, S4, S3, S2, S1, S0})
   ) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .req_line_n(req_line_n), .line_pull(line_pull),
      .power_fail(power_fail), .recall_req(recall_req),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .xfer_start(xfer_start), .xfer_store(xfer_store), .xfer_done(xfer_done),
      .store_count(store_count)
   );

   always @(negedge clk) if (rst_n && xfer_start) starts++;

   task automatic chk(input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic bus_idle();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      cyc(); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      cyc(); bus_idle(); #1;
   endtask

   task automatic do_write(input logic [AW-1:0] a);
      cyc(); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a;
      cyc(); bus_idle(); #1;
   endtask

   task automatic wait_done(output int n);
      n = 1;
      while (!xfer_done && n < 100) begin cyc(); #1; n++; end
   endtask

   task automatic t_reset();
      chk("R12 count after reset", store_count, 0);
      chk("R3 no pull after reset", line_pull, 0);
      chk("R8 no start after reset", xfer_start, 0);
      chk("R1 no read with idle bus", mem_rd_en, 0);
   endtask

   task automatic t_read_decode();
      cyc(); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 15'h0005; #1;
      chk("R1 read granted", mem_rd_en, 1);
      chk("R2 no write on read", mem_wr_en, 0);
      oe_n = 1'b1; #1;
      chk("R1 no read with oe high", mem_rd_en, 0);
      cyc(); bus_idle();
   endtask

   task automatic t_clean_skip();
      int pulls = 0, st0 = starts;
      cyc(); ext_req_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; #1;
      chk("R1 read refused with line low", mem_rd_en, 0);
      for (int i = 0; i < GR + XF + 2; i++) begin cyc(); #1; if (line_pull) pulls++; end
      ext_req_n = 1'b1; bus_idle(); power_fail = 1'b1;
      for (int i = 0; i < GR + XF + 2; i++) begin cyc(); #1; if (line_pull) pulls++; end
      power_fail = 1'b0;
      chk("R4 clean triggers never pull", pulls, 0);
      chk("R4 clean triggers start nothing", starts - st0, 0);
      chk("R4 count unchanged", store_count, 0);
   endtask

   task automatic t_write_decode();
      cyc(); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 15'h0010; #1;
      chk("R2 write granted", mem_wr_en, 1);
      oe_n = 1'b0; #1;
      chk("R2 write granted with oe low", mem_wr_en, 1);
      chk("R1 no read during write", mem_rd_en, 0);
      cyc(); bus_idle(); #1;
   endtask

   task automatic t_hw_store();
      int n;
      cyc(); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 15'h0007; #1;
      chk("R2 write before request", mem_wr_en, 1);
      cyc(); ext_req_n = 1'b0; #1;
      chk("R7 running write kept as line falls", mem_wr_en, 1);
      cyc(); #1;
      chk("R3 line pulled in grace", line_pull, 1);
      chk("R7 running write kept in grace", mem_wr_en, 1);
      we_n = 1'b1; oe_n = 1'b0; #1;
      chk("R7 read allowed in grace", mem_rd_en, 1);
      cyc(); we_n = 1'b0; oe_n = 1'b1; #1;
      chk("R7 new write refused in grace", mem_wr_en, 0);
      cyc(); bus_idle(); #1;
      chk("R7 still grace at last grace cycle", xfer_start, 0);
      cyc(); #1;
      chk("R7 transfer after grace", xfer_start, 1);
      chk("R8 store direction", xfer_store, 1);
      chk("R3 line pulled in transfer", line_pull, 1);
      ce_n = 1'b0; oe_n = 1'b0; ext_req_n = 1'b1; #1;
      chk("R6 read refused in transfer", mem_rd_en, 0);
      wait_done(n);
      chk("R8 transfer length", n, XF);
      bus_idle();
      cyc(); #1;
      chk("R8 done is one cycle", xfer_done, 0);
      chk("R3 pull released", line_pull, 0);
      chk("R12 first store counted", store_count, 1);
      ext_req_n = 1'b0;
      cyc(); cyc(); #1;
      chk("R11 dirty cleared by store", line_pull, 0);
      ext_req_n = 1'b1;
   endtask

   task automatic t_sw_store(input string tag, input int exp_cnt);
      int n;
      do_read(S0); do_read(S1); do_read(S2); do_read(S3); do_read(S4); do_read(S5);
      chk({tag, " R5 sequence starts store"}, xfer_start, 1);
      chk({tag, " R5 store direction"}, xfer_store, 1);
      chk({tag, " R3 pull on software store"}, line_pull, 1);
      wait_done(n);
      cyc(); #1;
      chk({tag, " R12 count"}, store_count, exp_cnt);
   endtask

   task automatic t_broken();
      int st0 = starts;
      do_read(S0); do_read(S1); do_read(S2); do_read(15'h0123);
      do_read(S3); do_read(S4); do_read(S5);
      chk("R9 wrong address breaks sequence", starts - st0, 0);
      do_read(S0); do_read(S1); do_read(S2); do_write(15'h0044);
      do_read(S3); do_read(S4); do_read(S5);
      chk("R9 write breaks sequence", starts - st0, 0);
   endtask

   task automatic t_power_fail();
      int n, st0;
      do_write(15'h0100);
      st0 = starts;
      cyc(); power_fail = 1'b1; #1;
      cyc(); power_fail = 1'b0; #1;
      chk("R3 pull on power-fail grace", line_pull, 1);
      chk("R7 grace before power-fail transfer", xfer_start, 0);
      cyc(); cyc(); cyc(); #1;
      chk("R7 power-fail transfer after grace", xfer_start, 1);
      wait_done(n);
      cyc(); #1;
      chk("R3 power-fail store ran", starts - st0, 1);
      chk("R12 counter saturates", store_count, 3);
   endtask

   task automatic t_recall();
      int n, pulls = 0;
      do_write(15'h0200);
      cyc(); recall_req = 1'b1; #1;
      cyc(); recall_req = 1'b0; #1;
      chk("R10 recall starts", xfer_start, 1);
      chk("R10 recall direction", xfer_store, 0);
      chk("R10 recall leaves line free", line_pull, 0);
      wait_done(n);
      chk("R8 recall length", n, XF);
      cyc(); #1;
      chk("R12 recall not counted", store_count, 3);
      ext_req_n = 1'b0;
      for (int i = 0; i < 4; i++) begin cyc(); #1; if (line_pull) pulls++; end
      ext_req_n = 1'b1;
      chk("R11 dirty cleared by recall", pulls, 0);
      cyc(); recall_req = 1'b1; #1;
      cyc(); recall_req = 1'b0; #1;
      chk("R10 recall runs when clean", xfer_start, 1);
      wait_done(n);
      cyc();
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc(); cyc(); cyc();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_read_decode();
      t_clean_skip();
      t_write_decode();
      t_hw_store();
      t_sw_store("clean", 2);
      t_broken();
      t_sw_store("after break", 3);
      t_power_fail();
      t_recall();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule